// File: doc/BRIEF.md
# Bang-Bang Supply Delay Regulator

This block keeps the supply of a digital load near the lowest voltage that still meets the requested clock speed. An external clock is halved to give a test clock with exactly 50% duty and a matching system clock. While the test clock is high, an on-chip delay line, which is outside this block, launches a test edge. When that high half ends, the block reads three synchronised flags. Each flag reports whether the edge failed to reach its tap: the critical-path tap, a tap one ripple length further on, and a far tap that shows an over-high supply.

From those flags, the switch state it drove before, and the limit last reached, the block drives an external converter through on/off controls: a charge switch, a discharge switch and an output switch. The output switch is closed whenever either of the other two is. The regulation is hysteretic. A supply that is too low charges until the ripple tap is reached. A supply that is too high discharges until the ripple tap is missed again. Between these events the load pulls the supply down slowly. The system clock reaches the load only while the supply is known to be high enough.

Top module: `vdd_bangbang_ctrl`

## Requirements
- R1: `test_clk_o` toggles on every rising edge of `clk_ext` out of reset, so it has a period of two external cycles and exactly 50% duty.
- R2: Tap flags pass through two flip-flop stages. They are evaluated once per test window, at the `clk_ext` edge that ends the high half of `test_clk_o`. Each flag is 1 when the test edge missed its tap and 0 when it reached the tap.
- R3: An evaluation that sees critical=1 and high=1 closes charge (`charge_o`=1) and opens discharge.
- R4: Once closed, charge stays closed while evaluations see critical=0 and ripple=1. It opens at the first evaluation that sees ripple=0.
- R5: An evaluation that sees critical=0 and high=0 closes discharge (`discharge_o`=1) and opens charge.
- R6: Discharge stays closed while later evaluations see ripple=0. It opens at the first evaluation that sees critical=0, high=1 and ripple=1.
- R7: With both switches open, an evaluation that sees critical=0 and high=1 leaves both open, whatever the ripple flag reads.
- R8: The contradictory reading critical=1 with high=0 opens both switches. Charge and discharge are never 1 in the same cycle.
- R9: `outsw_o` equals `charge_o` OR `discharge_o` in every cycle.
- R10: `ready_o` is set by an evaluation that sees critical=0. It clears on the first cycle in which the synchronised critical flag is 1, without waiting for the end of the window.
- R11: `sys_clk_o` follows `test_clk_o` while `ready_o` is 1 and is held at 0 while `ready_o` is 0.
- R12: A synchronous active-low reset opens all switches, clears `ready_o`, holds both clocks low, and presets the synchroniser to the "supply too low" reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext | input | 1 | External clock, twice the test clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_crit_i | input | 1 | Asynchronous flag: 1 means the edge missed the critical-path tap |
| tap_ripple_i | input | 1 | Asynchronous flag: 1 means the edge missed the ripple tap |
| tap_high_i | input | 1 | Asynchronous flag: 0 means the edge reached the far tap (supply too high) |
| test_clk_o | output | 1 | 50% duty test clock for the delay line |
| sys_clk_o | output | 1 | Gated system clock for the load |
| charge_o | output | 1 | 1 closes the converter input (charge) switch |
| discharge_o | output | 1 | 1 closes the output discharge switch |
| outsw_o | output | 1 | 1 closes the converter output switch |
| ready_o | output | 1 | Supply is high enough and the system clock runs |

## Verification
Several rules are checked on every cycle. The test clock must toggle on each edge. The switch state may change only at evaluation edges. Each flag combination must lead to the switch action it calls for, including the contradictory one. A synchronised critical miss must clear ready on the next cycle. The hysteresis depends on the order of events, so only the bench's sequences can show it: charge held through the (0,1,1) reading, discharge held through (0,0,1), and direct hand-over from charge to discharge. The same applies to the observable gating of the system clock, the latency of the synchroniser, and the effect of a reset in mid-run.

// File: rtl/vdd_ctrl_pkg.sv
// Shared types and tap indices for the bang-bang supply regulator.
// Assumes three tap flags ordered critical, ripple, high.
package vdd_ctrl_pkg;
    localparam int NUM_TAPS   = 3;
    localparam int TAP_CRIT   = 0;
    localparam int TAP_RIPPLE = 1;
    localparam int TAP_HIGH   = 2;

    typedef enum logic [1:0] {
        SW_IDLE      = 2'd0,
        SW_CHARGE    = 2'd1,
        SW_DISCHARGE = 2'd2
    } sw_state_t;
endpackage

// File: rtl/vdd_clk_div.sv
// Halves the external clock into a 50% duty test phase.
// eval_o marks the edge that ends the high half, where taps are judged.
// Assumes a synchronous active-low reset that parks the phase low.
module vdd_clk_div (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o,
    output logic eval_o
);
    logic phase_q;

    // Toggle the phase on every edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign phase_o = phase_q;
    assign eval_o  = rst_n & phase_q;

    // R1: the phase flips on every edge out of reset
    p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/vdd_tap_sync.sv
// Multi-stage synchroniser for the asynchronous tap flags.
// Reset presets every stage to 1, the "edge missed" reading,
// so the first decision after reset errs toward charging.
module vdd_tap_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw flags.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= raw_i;
                end
            end else begin : g_next
                // Pass the flags one stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/vdd_switch_fsm.sv
// Hysteretic switch controller. At each evaluation edge it picks
// charge, discharge or idle from the synchronised flags and the state
// it drove before. Between evaluations the state holds.
// Assumes flags use 1 = edge missed the tap.
module vdd_switch_fsm
    import vdd_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval_i,
    input  logic crit_i,
    input  logic ripple_i,
    input  logic high_i,
    output logic charge_o,
    output logic discharge_o
);
    sw_state_t state_q, state_d;

    // Choose the next switch state at an evaluation edge.
    always_comb begin
        state_d = state_q;
        if (eval_i) begin
            if (crit_i && !high_i)  state_d = SW_IDLE;
            else if (crit_i)        state_d = SW_CHARGE;
            else if (!high_i)       state_d = SW_DISCHARGE;
            else begin
                case (state_q)
                    SW_CHARGE:    state_d = ripple_i ? SW_CHARGE : SW_IDLE;
                    SW_DISCHARGE: state_d = ripple_i ? SW_IDLE : SW_DISCHARGE;
                    default:      state_d = SW_IDLE;
                endcase
            end
        end
    end

    // Hold the switch state between evaluations.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    assign charge_o    = (state_q == SW_CHARGE);
    assign discharge_o = (state_q == SW_DISCHARGE);

    // R2: the state moves only at an evaluation edge
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(state_q));
    // R3: a low supply reading closes charge
    p_charge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && crit_i && high_i) |=> (charge_o && !discharge_o));
    // R5: a high supply reading closes discharge
    p_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !crit_i && !high_i) |=> (discharge_o && !charge_o));
    // R8: a contradictory reading opens both switches
    p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && crit_i && !high_i) |=> (!charge_o && !discharge_o));
endmodule

// File: rtl/vdd_ready_track.sv
// Tracks whether the supply is high enough to run the load.
// Sets ready after an evaluation with the critical tap reached, and
// clears it on any cycle the synchronised critical flag shows a miss.
module vdd_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_i,
    input  logic crit_i,
    output logic ready_o
);
    logic ready_q;

    // Clear on a miss at once; set only at the end of a passing window.
    always_ff @(posedge clk) begin
        if (!rst_n)            ready_q <= 1'b0;
        else if (crit_i)       ready_q <= 1'b0;
        else if (eval_i)       ready_q <= 1'b1;
    end

    assign ready_o = ready_q;

    // R10: a synchronised critical miss drops ready on the next cycle
    p_ready_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        crit_i |=> !ready_q);
    // R10: a passing evaluation raises ready
    p_ready_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !crit_i) |=> ready_q);
endmodule

// File: rtl/vdd_bangbang_ctrl.sv
// Top of the bang-bang supply regulator: clock divider, tap
// synchroniser, switch controller and ready tracker. The system clock
// is the test phase gated by ready.
// Assumes the delay line is driven from test_clk_o.
module vdd_bangbang_ctrl
    import vdd_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ext,
    input  logic rst_n,
    input  logic tap_crit_i,
    input  logic tap_ripple_i,
    input  logic tap_high_i,
    output logic test_clk_o,
    output logic sys_clk_o,
    output logic charge_o,
    output logic discharge_o,
    output logic outsw_o,
    output logic ready_o
);
    logic                phase;
    logic                eval;
    logic [NUM_TAPS-1:0] raw_taps;
    logic [NUM_TAPS-1:0] sync_taps;
    logic                chg;
    logic                dis;
    logic                rdy;

    assign raw_taps[TAP_CRIT]   = tap_crit_i;
    assign raw_taps[TAP_RIPPLE] = tap_ripple_i;
    assign raw_taps[TAP_HIGH]   = tap_high_i;

    vdd_clk_div u_div (
        .clk     (clk_ext),
        .rst_n   (rst_n),
        .phase_o (phase),
        .eval_o  (eval)
    );

    vdd_tap_sync #(
        .WIDTH  (NUM_TAPS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk_ext),
        .rst_n  (rst_n),
        .raw_i  (raw_taps),
        .sync_o (sync_taps)
    );

    vdd_switch_fsm u_fsm (
        .clk         (clk_ext),
        .rst_n       (rst_n),
        .eval_i      (eval),
        .crit_i      (sync_taps[TAP_CRIT]),
        .ripple_i    (sync_taps[TAP_RIPPLE]),
        .high_i      (sync_taps[TAP_HIGH]),
        .charge_o    (chg),
        .discharge_o (dis)
    );

    vdd_ready_track u_rdy (
        .clk     (clk_ext),
        .rst_n   (rst_n),
        .eval_i  (eval),
        .crit_i  (sync_taps[TAP_CRIT]),
        .ready_o (rdy)
    );

    assign test_clk_o  = phase;
    assign sys_clk_o   = phase & rdy;
    assign charge_o    = chg;
    assign discharge_o = dis;
    assign outsw_o     = chg | dis;
    assign ready_o     = rdy;

    // R8: charge and discharge are never closed together
    p_excl_r8: assert property (@(posedge clk_ext) disable iff (!rst_n)
        !(charge_o && discharge_o));
    // R11: the gated clock runs after a passing evaluation
    p_gate_r11: assert property (@(posedge clk_ext) disable iff (!rst_n)
        (eval && !sync_taps[TAP_CRIT]) |=> ##1 (sys_clk_o || sync_taps[TAP_CRIT] || !rst_n));
endmodule

// File: tb/vdd_bangbang_ctrl_test.sv
// Self-checking bench: a vector table walked step by step, then
// directed tests for clocks, gating, ready latency and reset.
module vdd_bangbang_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    localparam int STEP_CYCLES = 4;

    // {crit, ripple, high, exp_charge, exp_discharge, exp_ready}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b111_100,  // 0  R3 low supply -> charge
        6'b011_101,  // 1  R4 charge held, ready set
        6'b001_001,  // 2  R4 ripple reached -> release
        6'b011_001,  // 3  R7 steady, both open
        6'b000_011,  // 4  R5 high supply -> discharge
        6'b001_011,  // 5  R6 discharge held
        6'b011_001,  // 6  R6 ripple missed -> release
        6'b110_000,  // 7  R8 contradictory -> both open
        6'b111_100,  // 8  R3 charge again
        6'b000_011,  // 9  R5 charge hands over to discharge
        6'b110_000,  // 10 R8 contradictory while discharging
        6'b011_001,  // 11 R7 steady
        6'b001_001,  // 12 R7 ripple alone has no effect
        6'b101_100   // 13 R3 critical wins over ripple
    };

    logic clk_ext = 1'b0;
    logic rst_n = 1'b0;
    logic tap_crit = 1'b0, tap_ripple = 1'b1, tap_high = 1'b1;
    logic test_clk, sys_clk, charge, discharge, outsw, ready;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_ext = ~clk_ext;

    vdd_bangbang_ctrl uut (
        .clk_ext      (clk_ext),
        .rst_n        (rst_n),
        .tap_crit_i   (tap_crit),
        .tap_ripple_i (tap_ripple),
        .tap_high_i   (tap_high),
        .test_clk_o   (test_clk),
        .sys_clk_o    (sys_clk),
        .charge_o     (charge),
        .discharge_o  (discharge),
        .outsw_o      (outsw),
        .ready_o      (ready)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0, 8, 13: return "R3";
            1, 2:     return "R4";
            4, 9:     return "R5";
            5, 6:     return "R6";
            7, 10:    return "R8";
            default:  return "R7";
        endcase
    endfunction

    task automatic set_taps(input logic c, input logic r, input logic h);
        tap_crit = c; tap_ripple = r; tap_high = h;
    endtask

    initial begin
        // R12: reset state
        set_taps(1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk_ext);
        check(charge, 1'b0, "R12 charge in reset");
        check(discharge, 1'b0, "R12 discharge in reset");
        check(ready, 1'b0, "R12 ready in reset");
        check(sys_clk, 1'b0, "R12 sys_clk in reset");
        check(test_clk, 1'b0, "R12 test_clk in reset");
        rst_n = 1'b1;

        // Table walk: each step has exactly one evaluation of the new flags (R2)
        for (int i = 0; i < NVEC; i++) begin
            set_taps(VEC[i][5], VEC[i][4], VEC[i][3]);
            repeat (STEP_CYCLES) @(negedge clk_ext);
            check(charge, VEC[i][2], {vec_tag(i), " charge"});
            check(discharge, VEC[i][1], {vec_tag(i), " discharge"});
            check(ready, VEC[i][0], "R10 ready");
            check(outsw, VEC[i][2] | VEC[i][1], "R9 outsw");
        end

        // R1 and R11: the system clock follows the test clock while ready
        set_taps(1'b0, 1'b1, 1'b1);
        repeat (STEP_CYCLES) @(negedge clk_ext);
        check(ready, 1'b1, "R10 ready before gating");
        for (int k = 0; k < 4; k++) begin
            logic prev;
            prev = test_clk;
            @(negedge clk_ext);
            check(test_clk, ~prev, "R1 test_clk toggles");
            check(sys_clk, test_clk, "R11 sys_clk follows");
        end

        // R10: ready clears three edges after a raw critical miss
        set_taps(1'b1, 1'b1, 1'b1);
        repeat (2) @(negedge clk_ext);
        check(ready, 1'b1, "R2 ready still set inside sync delay");
        @(negedge clk_ext);
        check(ready, 1'b0, "R10 ready clears at once");

        // R11: system clock held low while not ready
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_ext);
            check(sys_clk, 1'b0, "R11 sys_clk gated");
        end
        check(charge, 1'b1, "R3 charging before reset");

        // R12: reset in mid-run opens every switch
        rst_n = 1'b0;
        @(negedge clk_ext);
        check(charge, 1'b0, "R12 charge after reset");
        check(outsw, 1'b0, "R12 outsw after reset");
        check(ready, 1'b0, "R12 ready after reset");
        // R12: synchroniser preset reads "too low" right after release
        set_taps(1'b0, 1'b1, 1'b1);
        @(negedge clk_ext);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_ext);
        check(charge, 1'b1, "R12 preset flags charge first");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_ext);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule